// File: doc/BRIEF.md
# Gated-Clock Loadable Shift Register

This block is an 8-stage register with one serial output. On a clock edge it does one of two things. It can capture a parallel byte, or it can move every stage one place toward the output while a serial bit enters the first stage. A select input chooses between the two operations. The last stage drives the serial output. After a load, the top bit of the byte comes out first, and the remaining bits follow one per shift.

The system clock runs all the time. A hold input stops the register without stopping that clock. The hold is sampled as an ordinary clock enable on the rising edge, and no gated clock net is created. Because the hold is sampled, its transitions can never cause a step of their own.

An active-low clear forces every stage to zero at once. The clear is asynchronous when asserted. Its release passes through a short synchronizer, so the register never takes a partial step on the edge where clear goes away.

Top module: `gcsr_top`

## Requirements
- R1: While `clr_n` is low, every stage is zero and `ser_out` is 0. This takes effect at once, without waiting for a clock edge, and holds whatever the hold, select and data inputs are.
- R2: After `clr_n` rises, the register stays at zero through the first 2 rising edges (the synchronizer depth). The first operation happens on the 3rd rising edge.
- R3: On a rising edge with `step_hold`=0 and `shift_ld`=0, stage i takes `par_in[i]` for every i. Stage 7 drives `ser_out`, so `ser_out` equals `par_in[7]` after that edge.
- R4: During a load edge, `ser_in` has no effect on the captured value.
- R5: On a rising edge with `step_hold`=0 and `shift_ld`=1, stage 0 takes `ser_in` and each stage i>0 takes the old stage i-1.
- R6: After a load of byte P, `ser_out` shows P[7], then P[6] after the next shift, and so on down to P[0] after seven shifts.
- R7: On a rising edge with `step_hold`=1, no stage changes, in either mode and for any data.
- R8: When `step_hold` is held high over several edges and then released, operation resumes from the held contents. Releasing the hold does not cause an extra step.
- R9: Stages change only on a rising edge of `clk`. Input changes between edges leave `ser_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; rising edge active |
| clr_n | input | 1 | Active-low clear; asynchronous assert, synchronized release |
| step_hold | input | 1 | 1 blocks stepping on the current edge (clock enable, active high) |
| shift_ld | input | 1 | 1 = shift, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | 8 | Parallel byte; bit i loads stage i |
| ser_out | output | 1 | Last stage (stage 7) |

## Verification
A load or shift is visible on `ser_out` one rising edge after the inputs are applied. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and compares against its own model on the following falling edge.

A clear is due at once, so its check is taken one nanosecond after `clr_n` falls, with no clock edge in between. After a release, the model counts two edges of zero before it lets the next edge operate, and the bench compares on each of those edges. Changes between edges are checked a few nanoseconds after the inputs move, while `clk` is still low.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } gcsr_op_e;
endpackage

// File: rtl/gcsr_rst_sync.sv
module gcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

  // R2
  release_sync_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(srst_n) |-> $past(arst_n));
endmodule

// File: rtl/gcsr_step_ctl.sv
module gcsr_step_ctl
  import gcsr_pkg::*;
(
  input  logic     hold,
  input  logic     shift_sel,
  output gcsr_op_e op
);
  always_comb begin
    if (hold)           op = OP_IDLE;
    else if (shift_sel) op = OP_SHIFT;
    else                op = OP_LOAD;
  end
endmodule

// File: rtl/gcsr_stage_chain.sv
module gcsr_stage_chain
  import gcsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gcsr_op_e         op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_stage
      logic upstream;
      if (g == 0) begin : g_head
        assign upstream = ser_in;
      end else begin : g_body
        assign upstream = stage_q[g-1];
      end

      always_comb begin
        unique case (op)
          OP_LOAD:  stage_d[g] = par_in[g];
          OP_SHIFT: stage_d[g] = upstream;
          default:  stage_d[g] = stage_q[g];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign stages = stage_q;

  // R7
  hold_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> $stable(stage_q));

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (stage_q == $past(par_in)));

  // R5
  shift_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHIFT) |=> (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));
endmodule

// File: rtl/gcsr_top.sv
module gcsr_top
  import gcsr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             step_hold,
  input  logic             shift_ld,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic             rst_sync_n;
  gcsr_op_e         op;
  logic [WIDTH-1:0] stages;

  gcsr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (clr_n),
    .srst_n (rst_sync_n)
  );

  gcsr_step_ctl u_ctl (
    .hold      (step_hold),
    .shift_sel (shift_ld),
    .op        (op)
  );

  gcsr_stage_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .ser_in (ser_in),
    .par_in (par_in),
    .stages (stages)
  );

  assign ser_out = stages[LAST];

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst_sync_n)
    !clr_n |-> (stages == '0));
endmodule

// File: tb/gcsr_top_test.sv
module gcsr_top_test;
  localparam int  W   = 8;
  localparam time PER = 10ns;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         step_hold;
  logic         shift_ld;
  logic         ser_in;
  logic [W-1:0] par_in;
  logic         ser_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] mdl;
  int rel_cnt;

  always #(PER/2) clk = ~clk;

  gcsr_top uut (
    .clk       (clk),
    .clr_n     (clr_n),
    .step_hold (step_hold),
    .shift_ld  (shift_ld),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .ser_out   (ser_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: one rising edge
  task automatic model_edge();
    if (!clr_n) begin
      mdl = '0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else if (!step_hold) begin
      if (shift_ld) mdl = {mdl[W-2:0], ser_in};
      else          mdl = par_in;
    end
  endtask

  // drive at falling edge, one rising edge, compare at next falling edge
  task automatic edge_op(input logic sl, input logic si, input logic [W-1:0] pi,
                         input logic hold, input string tag);
    shift_ld = sl; ser_in = si; par_in = pi; step_hold = hold;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(ser_out, mdl[W-1], tag);
  endtask

  task automatic t_reset();
    clr_n = 1'b0; step_hold = 1'b0; shift_ld = 1'b0; ser_in = 1'b1; par_in = 8'hFF;
    mdl = '0; rel_cnt = 0;
    repeat (3) edge_op(1'b0, 1'b1, 8'hFF, 1'b0, "R1 reset holds zero");
    @(negedge clk);
    clr_n = 1'b1;
    edge_op(1'b0, 1'b1, 8'hFF, 1'b0, "R2 release edge 1");
    edge_op(1'b0, 1'b1, 8'hFF, 1'b0, "R2 release edge 2");
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R2 first load on edge 3");
  endtask

  task automatic t_load_unload(input logic [W-1:0] p);
    edge_op(1'b0, 1'b0, p, 1'b0, "R3 load msb out");
    for (int i = 0; i < W-1; i++)
      edge_op(1'b1, 1'b0, ~p, 1'b0, "R6 unload order");
  endtask

  task automatic t_serial(input logic [15:0] pat);
    for (int i = 15; i >= 0; i--)
      edge_op(1'b1, pat[i], 8'h00, 1'b0, "R5 serial shift");
  endtask

  task automatic t_load_ignores_serial();
    edge_op(1'b0, 1'b1, 8'h00, 1'b0, "R4 load with ser_in=1");
    for (int i = 0; i < W-1; i++)
      edge_op(1'b1, 1'b0, 8'h00, 1'b0, "R4 loaded zeros only");
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R4 load with ser_in=0");
    for (int i = 0; i < W-1; i++)
      edge_op(1'b1, 1'b1, 8'h00, 1'b0, "R4 loaded ones only");
  endtask

  task automatic t_hold();
    edge_op(1'b0, 1'b0, 8'b1011_0010, 1'b0, "R3 load before hold");
    edge_op(1'b0, 1'b1, 8'h00, 1'b1, "R7 hold in load mode");
    edge_op(1'b1, 1'b0, 8'h00, 1'b1, "R7 hold in shift mode");
    repeat (4) edge_op(1'b1, 1'b1, 8'h5A, 1'b1, "R8 hold across edges");
    for (int i = 0; i < W-1; i++)
      edge_op(1'b1, 1'b0, 8'h00, 1'b0, "R8 resume after hold");
  endtask

  task automatic t_between_edges();
    edge_op(1'b0, 1'b0, 8'h80, 1'b0, "R9 setup load");
    shift_ld = 1'b0; par_in = 8'h00; step_hold = 1'b0; ser_in = 1'b0;
    #2;
    check(ser_out, mdl[W-1], "R9 no change between edges");
    shift_ld = 1'b1;
    #1;
    check(ser_out, mdl[W-1], "R9 mode change between edges");
    @(negedge clk);
  endtask

  task automatic t_clear_midshift();
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R3 load ones");
    edge_op(1'b1, 1'b1, 8'h00, 1'b0, "R5 shift before clear");
    #2;
    clr_n = 1'b0;
    mdl = '0; rel_cnt = 0;
    #1;
    check(ser_out, 1'b0, "R1 asynchronous clear");
    @(negedge clk);
    edge_op(1'b0, 1'b1, 8'hFF, 1'b0, "R1 clear beats load");
    edge_op(1'b1, 1'b1, 8'hFF, 1'b1, "R1 clear beats shift");
    clr_n = 1'b1;
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R2 held zero edge 1");
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R2 held zero edge 2");
    edge_op(1'b0, 1'b0, 8'hFF, 1'b0, "R2 operate edge 3");
  endtask

  initial begin
    #(PER * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_unload(8'b1100_1010);
    t_load_unload(8'b0011_0101);
    t_serial(16'b1001_1101_0110_0011);
    t_load_ignores_serial();
    t_hold();
    t_between_edges();
    t_clear_midshift();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule